// File: doc/BRIEF.md
# Programmable Clamp Pulse Generator

This block produces a black-level clamp window for a video front end, timed in pixel clocks from the horizontal sync. In internal mode it waits for the trailing edge of the sync pulse, counts a programmed placement delay, and then holds the clamp output high for a programmed number of pixel clocks. The window is meant to land in the back porch, where the incoming signal shows a stable black reference.

A select input switches the block to external mode. In that mode the clamp output is a one-clock registered copy of an external clamp input, and the sync input and both count settings have no effect. The two 8-bit settings are sampled only at a sync trailing edge. A change made in the middle of a line therefore applies from the next line onward.

Top module: `clampGen`

## Requirements
- R1: With `extSel` = 0, a trailing edge is the first rising clock edge at which `hsyncIn` (active high) is sampled 0 after it was sampled 1 at the edge before. If `placeCfg` = P (1..255), `clampOut` first reads 1 after clock edge E+P, where E is that trailing-edge clock.
- R2: Once `clampOut` has risen in internal mode, it stays 1 for exactly D = `durCfg` (1..255) clock cycles and then returns to 0.
- R3: A `placeCfg` of 0 acts as 1, so the window starts one clock after the trailing edge. `clampOut` is never 1 in the cycle right after an internal trailing edge.
- R4: A `durCfg` of 0 produces no clamp pulse on that line.
- R5: With `extSel` = 1, `clampOut` equals `extClampIn` as sampled at the previous clock edge. In this mode `hsyncIn`, `placeCfg` and `durCfg` have no effect on the output.
- R6: A trailing edge that arrives while a window is pending or active cancels that window. `clampOut` is 0 after that edge, and a new window is timed from it.
- R7: `placeCfg` and `durCfg` are captured at the trailing edge. Changes made after that edge do not alter the current window and take effect on the next line.
- R8: While `rst` (synchronous, active high) is asserted and after it is released, `clampOut` is 0 until a window or external-mode input drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncIn | input | 1 | Horizontal sync, active high |
| extClampIn | input | 1 | Clamp input used in external mode |
| extSel | input | 1 | 1 selects external clamp, 0 selects the internal window |
| placeCfg | input | 8 | Delay from the sync trailing edge to the start of the clamp, in pixel clocks |
| durCfg | input | 8 | Clamp width in pixel clocks |
| clampOut | output | 1 | Registered clamp output |

## Verification
The assertions check several rules on every cycle: the one-clock registered pass-through in external mode, that the output is low after any trailing edge, that a window is cancelled and restarted on each new edge, that the output rises only at the end of the placement wait, and that a zero duration keeps the output low. Some properties depend on a whole line and cannot be seen in one cycle. These are the exact rise offset and width for a given placement and duration, placement 0 acting as 1, and settings written mid-line being deferred to the next line. The bench's scenarios show these by measuring complete lines.

// File: rtl/clampGenPkg.sv
package clampGenPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2
  } clampState_t;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic capture;  // latch settings, load placement wait
    logic loadDur;  // load duration count
    logic dec;      // count down one pixel
  } cntStrobe_t;

endpackage

// File: rtl/clampGenCount.sv
module clampGenCount
  import clampGenPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] placeCfg,
  input  logic [CNT_W-1:0] durCfg,
  output logic             cntZero,
  output logic             durZero
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] durLatch;
  logic [CNT_W-1:0] placeLoad;

  // a zero placement is promoted to one pixel: remaining count 0
  always_comb begin
    if (placeCfg == '0) placeLoad = '0;
    else                placeLoad = placeCfg - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      durLatch <= '0;
    end else if (strobe.capture) begin
      cnt      <= placeLoad;
      durLatch <= durCfg;
    end else if (strobe.loadDur) begin
      cnt      <= durLatch - CNT_ONE;
    end else if (strobe.dec) begin
      cnt      <= cnt - CNT_ONE;
    end
  end

  assign cntZero = (cnt == '0);
  assign durZero = (durLatch == '0);

  // R2: each decrement strobe lowers the remaining count by exactly one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.dec && !strobe.capture && !strobe.loadDur) |=> cnt == CNT_W'($past(cnt) - CNT_ONE));

endmodule

// File: rtl/clampGenCtrl.sv
module clampGenCtrl
  import clampGenPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hsyncIn,
  input  logic       extSel,
  input  logic       extClampIn,
  input  logic       cntZero,
  input  logic       durZero,
  output cntStrobe_t strobe,
  output logic       clampOut
);

  clampState_t state, stateNext;
  logic        hsyncPrev;
  logic        trailEdge;
  logic        clampNext;

  always_ff @(posedge clk) begin
    if (rst) hsyncPrev <= 1'b0;
    else     hsyncPrev <= hsyncIn;
  end

  assign trailEdge = hsyncPrev & ~hsyncIn;

  always_comb begin
    stateNext = state;
    clampNext = 1'b0;
    strobe    = '0;
    if (extSel) begin
      stateNext = ST_IDLE;
    end else if (trailEdge) begin
      stateNext      = ST_WAIT;
      strobe.capture = 1'b1;
    end else begin
      case (state)
        ST_WAIT: begin
          if (cntZero) begin
            if (durZero) begin
              stateNext = ST_IDLE;
            end else begin
              stateNext      = ST_ACTIVE;
              strobe.loadDur = 1'b1;
              clampNext      = 1'b1;
            end
          end else begin
            strobe.dec = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cntZero) begin
            stateNext = ST_IDLE;
          end else begin
            strobe.dec = 1'b1;
            clampNext  = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      clampOut <= 1'b0;
    end else begin
      state    <= stateNext;
      clampOut <= extSel ? extClampIn : clampNext;
    end
  end

  // R1: the output rises only when the placement wait runs out
  assert_rise_after_wait_R1: assert property (@(posedge clk) disable iff (rst)
    ($rose(clampOut) && !$past(extSel)) |-> ($past(state) == ST_WAIT && $past(cntZero)));

  // R2: an active window with count left keeps the output high
  assert_hold_active_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACTIVE && !cntZero && !extSel && !trailEdge) |=> clampOut);

  // R3: never high in the cycle right after an internal trailing edge
  assert_edge_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (trailEdge && !extSel) |=> !clampOut);

  // R4: zero duration ends the line without a pulse
  assert_zero_dur_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && cntZero && durZero && !extSel && !trailEdge) |=> (!clampOut && state == ST_IDLE));

  // R5: external mode is a one-clock registered pass-through
  assert_ext_follow_R5: assert property (@(posedge clk) disable iff (rst)
    extSel |=> clampOut == $past(extClampIn));

  // R6: every internal trailing edge restarts the placement wait
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (trailEdge && !extSel) |=> state == ST_WAIT);

endmodule

// File: rtl/clampGen.sv
module clampGen
  import clampGenPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsyncIn,
  input  logic             extClampIn,
  input  logic             extSel,
  input  logic [CNT_W-1:0] placeCfg,
  input  logic [CNT_W-1:0] durCfg,
  output logic             clampOut
);

  cntStrobe_t strobe;
  logic       cntZero;
  logic       durZero;

  clampGenCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hsyncIn    (hsyncIn),
    .extSel     (extSel),
    .extClampIn (extClampIn),
    .cntZero    (cntZero),
    .durZero    (durZero),
    .strobe     (strobe),
    .clampOut   (clampOut)
  );

  clampGenCount #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .placeCfg (placeCfg),
    .durCfg   (durCfg),
    .cntZero  (cntZero),
    .durZero  (durZero)
  );

endmodule

// File: tb/sim_clampGen.sv
`timescale 1ns/1ps
module sim_clampGen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsyncIn = 1'b0;
  logic       extClampIn = 1'b0;
  logic       extSel = 1'b0;
  logic [7:0] placeCfg = 8'd1;
  logic [7:0] durCfg = 8'd1;
  logic       clampOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  localparam int MEAS_LEN = 520;
  localparam int NVEC = 8;
  // placement, duration, expected rise offset, expected width
  localparam int VEC [NVEC][4] = '{
    '{  1,   1,   1,   1},
    '{  0,   4,   1,   4},
    '{ 10,   5,  10,   5},
    '{255, 255, 255, 255},
    '{  3,   0,  -1,   0},
    '{ 20,   1,  20,   1},
    '{  2, 200,   2, 200},
    '{128,   7, 128,   7}
  };

  always #2.5 clk = ~clk;

  clampGen u0 (
    .clk        (clk),
    .rst        (rst),
    .hsyncIn    (hsyncIn),
    .extClampIn (extClampIn),
    .extSel     (extSel),
    .placeCfg   (placeCfg),
    .durCfg     (durCfg),
    .clampOut   (clampOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sync high for three clocks, low at a falling edge; next rising edge is E
  task automatic pulseSync();
    @(negedge clk);
    hsyncIn = 1'b1;
    repeat (3) @(negedge clk);
    hsyncIn = 1'b0;
  endtask

  // measure rise offset and width from edge E; optional setting write at wrK
  task automatic measure(output int first, output int width,
                         input int wrK, input int wrP, input int wrD);
    first = -1;
    width = 0;
    for (int k = 0; k < MEAS_LEN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (clampOut) begin
        if (first < 0) first = k;
        width++;
      end
      if (k == wrK) begin
        placeCfg = 8'(wrP);
        durCfg   = 8'(wrD);
      end
    end
  endtask

  initial begin
    int first, width;
    repeat (3) @(negedge clk);
    check("R8 clamp low in reset", int'(clampOut), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 clamp low after reset", int'(clampOut), 0);

    // vector table: R1 rise offset, R2 width, R3 zero placement, R4 zero duration
    for (int v = 0; v < NVEC; v++) begin
      placeCfg = 8'(VEC[v][0]);
      durCfg   = 8'(VEC[v][1]);
      pulseSync();
      measure(first, width, -1, 0, 0);
      check($sformatf("R1/R3 rise vec%0d", v), first, VEC[v][2]);
      check($sformatf("R2/R4 width vec%0d", v), width, VEC[v][3]);
    end

    // R6: restart while a window is active
    placeCfg = 8'd3;
    durCfg   = 8'd20;
    pulseSync();
    repeat (8) @(posedge clk);
    @(negedge clk);
    check("R6 active before restart", int'(clampOut), 1);
    pulseSync();
    measure(first, width, -1, 0, 0);
    check("R6 rise after restart", first, 3);
    check("R6 width after restart", width, 20);

    // R6: restart while the placement wait is pending
    placeCfg = 8'd10;
    durCfg   = 8'd5;
    pulseSync();
    repeat (4) @(posedge clk);
    pulseSync();
    measure(first, width, -1, 0, 0);
    check("R6 pending restart rise", first, 10);
    check("R6 pending restart width", width, 5);

    // R7: mid-line write deferred to next line
    placeCfg = 8'd10;
    durCfg   = 8'd5;
    pulseSync();
    measure(first, width, 2, 50, 2);
    check("R7 current line rise", first, 10);
    check("R7 current line width", width, 5);
    pulseSync();
    measure(first, width, -1, 0, 0);
    check("R7 next line rise", first, 50);
    check("R7 next line width", width, 2);

    // R5: external pass-through, one clock late
    @(negedge clk);
    extSel = 1'b1;
    placeCfg = 8'd1;
    durCfg   = 8'd10;
    for (int i = 0; i < 12; i++) begin
      extClampIn = ((i % 3) == 1) || (i == 7);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R5 follow step%0d", i), int'(clampOut), int'(extClampIn));
    end
    // R5: sync edge and settings have no effect in external mode
    extClampIn = 1'b0;
    pulseSync();
    measure(first, width, -1, 0, 0);
    check("R5 no internal pulse", width, 0);
    extClampIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 external high held", int'(clampOut), 1);
    extClampIn = 1'b0;
    @(negedge clk);
    extSel = 1'b0;
    @(negedge clk);
    check("R5 back to internal idle", int'(clampOut), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule